// File: doc/BRIEF.md
# Five-Oscillator Complex Baseband Synthesiser

This block produces one complex baseband stream, one in-phase and one quadrature sample on every clock, where each clock is one sample period. Five numerically controlled oscillators run side by side. Each one has a 32-bit phase increment, a 16-bit phase offset, a 15-bit unsigned amplitude and two ways of clearing its phase accumulator. The five complex products are added and clipped to a 14-bit signed result. A sticky flag records any clipping.

Software programs an oscillator through a single write port that carries an oscillator index, a field selector and a 32-bit data word. Increment, offset and amplitude writes go into staging registers. A control write with the apply bit set copies all three staged words into the running oscillator on the same edge, so a retune never produces a sample that mixes old and new words. The path from an applied write to the output has a fixed length of four registers.

Top module: `nco_bank`

## Requirements
- R1: In the cycle after a synchronous reset, `out_i`, `out_q` and `sat_flag` are all zero, and every staged word, running word and accumulator is zero.
- R2: A write with `wr_sel` 0 stages the increment from `wr_data[31:0]`, 1 stages the offset from `wr_data[15:0]`, and 2 stages the amplitude from `wr_data[14:0]`. A staged word alone never changes the output.
- R3: A write with `wr_sel` 3 and `wr_data[2]` set copies all three staged words into the running oscillator at that edge. The first output sample that uses the new offset and amplitude appears after the fourth rising edge that follows the write edge.
- R4: On every clock, each accumulator adds its running increment modulo 2^32. The table address is bits [15:8] of (accumulator[31:16] + offset), so the table has 256 points per turn. The sine entry at address k is round(32767·sin(2πk/256)), and the cosine entry is the sine entry at k+64. Each oscillator adds floor(cos·amp/2^17) to I and floor(sin·amp/2^17) to Q.
- R5: A control write (`wr_sel` 3) loads `wr_data[0]` as a persistent clear. While it is set, the accumulator reads zero on every following cycle.
- R6: A control write with `wr_data[1]` set clears the accumulator on exactly one edge, the edge after the write. After that edge, accumulation resumes from zero.
- R7: The five contributions are added at full precision. The sum is limited to the range -8192 to 8191 in each quadrature instead of wrapping.
- R8: `sat_flag` goes high in the same cycle as the first output that needed limiting. It then stays high until reset, and it never goes high while no sum has left the 14-bit range.
- R9: A write whose `wr_osc` is 5, 6 or 7 changes no oscillator and has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_osc | input | 3 | Oscillator index (0 to 4 valid) |
| wr_sel | input | 2 | Field: 0 increment, 1 offset, 2 amplitude, 3 control |
| wr_data | input | 32 | Write data; for control, bit 0 holds clear, bit 1 one-shot clear, bit 2 apply |
| out_i | output | 14 | Saturated in-phase sum, two's complement |
| out_q | output | 14 | Saturated quadrature sum, two's complement |
| sat_flag | output | 1 | Sticky indication that limiting occurred |

## Verification
The hardest state to reach is all five oscillators at full amplitude with the same known phase, which is what drives the sum into limiting in a predictable direction. The stimulus gets there by applying a zero increment, a zero offset and full amplitude to every oscillator together with the persistent clear. This pins every phase at zero, so I lands on the positive rail. An offset of half a turn then moves I to the negative rail. Before that step, the stimulus walks the oscillators through staged-but-unapplied words, mixed increments, both clear modes and writes to unused indices. A reference model computes every output sample and compares it on every clock, so a single cycle of wrong latency shows up as a mismatch.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int FTW_W  = 32;
    localparam int POW_W  = 16;
    localparam int AMP_W  = 15;
    localparam int OUT_W  = 14;
    localparam int IDX_W  = 8;
    localparam int SIN_W  = 16;
    localparam int TAB_N  = 1 << IDX_W;
    localparam int QUART  = TAB_N / 4;
    localparam int PROD_W = SIN_W + AMP_W + 1;
    localparam int SHIFT  = (SIN_W - 1) + AMP_W - (OUT_W - 1);

    // pi in Q30 fixed point
    localparam longint PI_Q30  = 64'sd3373259426;
    localparam longint STEP_Q30 = PI_Q30 / (TAB_N / 2);

    typedef enum logic [1:0] {
        SEL_FTW  = 2'd0,
        SEL_POW  = 2'd1,
        SEL_AMP  = 2'd2,
        SEL_CTRL = 2'd3
    } nco_sel_e;

    typedef struct packed {
        logic [FTW_W-1:0] ftw;
        logic [POW_W-1:0] pw;
        logic [AMP_W-1:0] amp;
    } osc_words_t;

    // Sine of table point k, scaled by 2^(SIN_W-1)-1, rounded; Taylor series in Q30.
    function automatic logic signed [SIN_W-1:0] sine_point(input int k);
        longint x, x2, term, acc;
        int q, r;
        q = k / QUART;
        r = k % QUART;
        x = longint'((q % 2 == 1) ? (QUART - r) : r) * STEP_Q30;
        x2 = (x * x) >>> 30;
        term = x;
        acc = x;
        for (int n = 1; n <= 7; n++) begin
            term = -((term * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
            acc = acc + term;
        end
        acc = (acc * longint'((1 << (SIN_W - 1)) - 1) + (64'sd1 <<< 29)) >>> 30;
        if (q >= 2) acc = -acc;
        return SIN_W'(acc);
    endfunction

    function automatic logic [TAB_N*SIN_W-1:0] build_sine();
        logic [TAB_N*SIN_W-1:0] t;
        t = '0;
        for (int k = 0; k < TAB_N; k++) t[k*SIN_W +: SIN_W] = sine_point(k);
        return t;
    endfunction

endpackage

// File: rtl/nco_osc.sv
module nco_osc
    import nco_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_hit,
    input  logic [1:0]              wr_sel,
    input  logic [FTW_W-1:0]        wr_data,
    output logic signed [OUT_W-1:0] prod_i,
    output logic signed [OUT_W-1:0] prod_q
);

    localparam logic [TAB_N*SIN_W-1:0] SIN_TAB = build_sine();

    osc_words_t stage_q, live_q;
    logic       hold_q, once_q;
    logic [FTW_W-1:0] acc_q;
    logic [IDX_W-1:0] idx_q, idx_n, cos_idx;
    logic [POW_W-IDX_W-1:0] unused_ph_lo;
    logic [AMP_W-1:0] amp_d1, amp_d2;
    logic signed [SIN_W-1:0] sin_r, cos_r;
    logic signed [PROD_W-1:0] p_i, p_q;
    logic clear, commit;

    assign commit = wr_hit && (wr_sel == SEL_CTRL) && wr_data[2];
    assign clear  = hold_q || once_q;

    // Staging and running words
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            hold_q  <= 1'b0;
            once_q  <= 1'b0;
        end else begin
            once_q <= 1'b0;
            if (wr_hit) begin
                unique case (wr_sel)
                    SEL_FTW: stage_q.ftw <= wr_data;
                    SEL_POW: stage_q.pw  <= wr_data[POW_W-1:0];
                    SEL_AMP: stage_q.amp <= wr_data[AMP_W-1:0];
                    default: begin
                        hold_q <= wr_data[0];
                        once_q <= wr_data[1];
                    end
                endcase
            end
            if (commit) live_q <= stage_q;
        end
    end

    // Phase accumulator and table pipeline
    assign {idx_n, unused_ph_lo} = acc_q[FTW_W-1 -: POW_W] + live_q.pw;
    assign cos_idx = idx_q + IDX_W'(QUART);
    assign p_i = cos_r * $signed({1'b0, amp_d2});
    assign p_q = sin_r * $signed({1'b0, amp_d2});

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            idx_q  <= '0;
            amp_d1 <= '0;
            amp_d2 <= '0;
            sin_r  <= '0;
            cos_r  <= '0;
            prod_i <= '0;
            prod_q <= '0;
        end else begin
            acc_q  <= clear ? '0 : acc_q + live_q.ftw;
            idx_q  <= idx_n;
            amp_d1 <= live_q.amp;
            amp_d2 <= amp_d1;
            sin_r  <= SIN_TAB[idx_q*SIN_W +: SIN_W];
            cos_r  <= SIN_TAB[cos_idx*SIN_W +: SIN_W];
            prod_i <= OUT_W'(p_i >>> SHIFT);
            prod_q <= OUT_W'(p_q >>> SHIFT);
        end
    end

    // R3: running words move only on an apply write
    assert_apply_atomic_R3: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(live_q));

    // R2: staged words move only on a write to this oscillator
    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(stage_q));

    // R5 and R6: a pending clear zeroes the accumulator on the next edge
    assert_acc_cleared_R5: assert property (@(posedge clk) disable iff (rst)
        (hold_q || once_q) |=> (acc_q == '0));

endmodule

// File: rtl/nco_sum.sv
module nco_sum
    import nco_pkg::*;
#(
    parameter int NUM_OSC = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [OUT_W-1:0] in_i [NUM_OSC],
    input  logic signed [OUT_W-1:0] in_q [NUM_OSC],
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q,
    output logic                    sat_flag
);

    localparam int SUM_W = OUT_W + $clog2(NUM_OSC) + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(1 << (OUT_W - 1));
    localparam logic signed [OUT_W-1:0] HI_O = OUT_W'(HI);
    localparam logic signed [OUT_W-1:0] LO_O = OUT_W'(LO);

    logic signed [SUM_W-1:0] sum_i, sum_q;
    logic signed [OUT_W-1:0] lim_i, lim_q;
    logic over_i, over_q;

    always_comb begin
        sum_i = '0;
        sum_q = '0;
        for (int k = 0; k < NUM_OSC; k++) begin
            sum_i = sum_i + SUM_W'(in_i[k]);
            sum_q = sum_q + SUM_W'(in_q[k]);
        end
        over_i = (sum_i > HI) || (sum_i < LO);
        over_q = (sum_q > HI) || (sum_q < LO);
        lim_i  = (sum_i > HI) ? HI_O : (sum_i < LO) ? LO_O : OUT_W'(sum_i);
        lim_q  = (sum_q > HI) ? HI_O : (sum_q < LO) ? LO_O : OUT_W'(sum_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_i    <= '0;
            out_q    <= '0;
            sat_flag <= 1'b0;
        end else begin
            out_i    <= lim_i;
            out_q    <= lim_q;
            sat_flag <= sat_flag || over_i || over_q;
        end
    end

    // R8: once raised, the flag stays raised
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        sat_flag |=> sat_flag);

    // R7: the flag rises only together with a sample on a rail
    assert_rise_on_rail_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> (out_i == HI_O || out_i == LO_O ||
                             out_q == HI_O || out_q == LO_O));

endmodule

// File: rtl/nco_bank.sv
module nco_bank
    import nco_pkg::*;
#(
    parameter int NUM_OSC = 5,
    localparam int OSC_IDX_W = $clog2(NUM_OSC)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [OSC_IDX_W-1:0] wr_osc,
    input  logic [1:0]           wr_sel,
    input  logic [FTW_W-1:0]     wr_data,
    output logic [OUT_W-1:0]     out_i,
    output logic [OUT_W-1:0]     out_q,
    output logic                 sat_flag
);

    logic signed [OUT_W-1:0] prod_i [NUM_OSC];
    logic signed [OUT_W-1:0] prod_q [NUM_OSC];
    logic signed [OUT_W-1:0] sum_i, sum_q;

    for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
        nco_osc u_osc (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_en && (wr_osc == OSC_IDX_W'(g))),
            .wr_sel  (wr_sel),
            .wr_data (wr_data),
            .prod_i  (prod_i[g]),
            .prod_q  (prod_q[g])
        );
    end

    nco_sum #(.NUM_OSC(NUM_OSC)) u_sum (
        .clk      (clk),
        .rst      (rst),
        .in_i     (prod_i),
        .in_q     (prod_q),
        .out_i    (sum_i),
        .out_q    (sum_q),
        .sat_flag (sat_flag)
    );

    assign out_i = sum_i;
    assign out_q = sum_q;

endmodule

// File: tb/sim_nco_bank.sv
module sim_nco_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_osc = '0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [13:0] out_i, out_q;
    logic        sat_flag;

    always #2 clk = ~clk;   // 250 MHz

    nco_bank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_osc(wr_osc),
        .wr_sel(wr_sel), .wr_data(wr_data),
        .out_i(out_i), .out_q(out_q), .sat_flag(sat_flag)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;
    bit chk_en = 0;
    string cur_req = "R1";

    // Reference model state
    int       tab [256];
    bit [31:0] m_acc [5], m_ftw [5], s_ftw [5];
    bit [15:0] m_pow [5], s_pow [5];
    bit [14:0] m_amp [5], s_amp [5];
    bit        m_hold [5], m_once [5];
    bit        m_flag = 0;
    int  qi [$], qq [$];
    bit  qo [$];
    int  exp_i = 0, exp_q = 0;
    bit  exp_ok = 0;

    initial begin
        for (int k = 0; k < 256; k++)
            tab[k] = $rtoi($floor(32767.0 * $sin(2.0 * 3.14159265358979323846 * k / 256.0) + 0.5));
    end

    function automatic void calc(output int ei, output int eq, output bit ov);
        int si, sq, ix, cx;
        bit [15:0] ph;
        si = 0; sq = 0;
        for (int o = 0; o < 5; o++) begin
            ph = m_acc[o][31:16] + m_pow[o];
            ix = int'(ph[15:8]);
            cx = (ix + 64) % 256;
            si += (tab[cx] * int'(m_amp[o])) >>> 17;
            sq += (tab[ix] * int'(m_amp[o])) >>> 17;
        end
        ov = (si > 8191) || (si < -8192) || (sq > 8191) || (sq < -8192);
        ei = (si > 8191) ? 8191 : (si < -8192) ? -8192 : si;
        eq = (sq > 8191) ? 8191 : (sq < -8192) ? -8192 : sq;
    endfunction

    always @(posedge clk) begin
        int ei, eq;
        bit ov;
        if (rst) begin
            for (int o = 0; o < 5; o++) begin
                m_acc[o] = 0; m_ftw[o] = 0; s_ftw[o] = 0;
                m_pow[o] = 0; s_pow[o] = 0; m_amp[o] = 0; s_amp[o] = 0;
                m_hold[o] = 0; m_once[o] = 0;
            end
            m_flag = 0;
        end else begin
            for (int o = 0; o < 5; o++) begin
                m_acc[o] = (m_hold[o] || m_once[o]) ? 32'd0 : m_acc[o] + m_ftw[o];
                m_once[o] = 0;
            end
            if (wr_en && wr_osc < 3'd5) begin
                case (wr_sel)
                    2'd0: s_ftw[wr_osc] = wr_data;
                    2'd1: s_pow[wr_osc] = wr_data[15:0];
                    2'd2: s_amp[wr_osc] = wr_data[14:0];
                    default: begin
                        m_hold[wr_osc] = wr_data[0];
                        m_once[wr_osc] = wr_data[1];
                        if (wr_data[2]) begin
                            m_ftw[wr_osc] = s_ftw[wr_osc];
                            m_pow[wr_osc] = s_pow[wr_osc];
                            m_amp[wr_osc] = s_amp[wr_osc];
                        end
                    end
                endcase
            end
        end
        calc(ei, eq, ov);
        qi.push_back(ei); qq.push_back(eq); qo.push_back(ov);
        if (qi.size() > 4) begin
            exp_i = qi.pop_front();
            exp_q = qq.pop_front();
            if (rst) m_flag = 0; else m_flag = m_flag | qo.pop_front();
            if (rst) void'(qo.pop_front());
            exp_ok = 1;
        end
    end

    function automatic bit near(input logic [13:0] act, input int e);
        int a, d;
        a = int'($signed(act));
        d = a - e;
        return (d <= 2) && (d >= -2);
    endfunction

    always @(negedge clk) begin
        if (chk_en && exp_ok && !done) begin
            vectors++;
            if (!near(out_i, exp_i) || !near(out_q, exp_q) || sat_flag !== m_flag) begin
                miscompares++;
                $display("FAIL %s: out_i=%0d out_q=%0d flag=%0b expected %0d %0d %0b",
                         cur_req, $signed(out_i), $signed(out_q), sat_flag, exp_i, exp_q, m_flag);
            end
        end
    end

    task automatic check(input string req, input bit cond, input int act, input int e);
        vectors++;
        if (!cond) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, e);
        end
    endtask

    task automatic wr(input int o, input int s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_osc = 3'(o); wr_sel = 2'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_osc(input int o, input logic [31:0] f, input logic [15:0] p,
                           input logic [14:0] a, input logic [2:0] ctl);
        wr(o, 0, f);
        wr(o, 1, {16'd0, p});
        wr(o, 2, {17'd0, a});
        wr(o, 3, {29'd0, ctl});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        check("R1", out_i == 0, int'($signed(out_i)), 0);
        check("R1", out_q == 0, int'($signed(out_q)), 0);
        check("R1", sat_flag == 0, int'(sat_flag), 0);
        chk_en = 1;

        // R2: staged words alone change nothing
        cur_req = "R2";
        wr(0, 0, 32'd0);
        wr(0, 1, 32'd0);
        wr(0, 2, 32'd32767);
        idle(8);
        check("R2", out_i == 0, int'($signed(out_i)), 0);

        // R3: apply and four-edge latency
        cur_req = "R3";
        wr(0, 3, 32'd4);
        idle(3);
        check("R3", out_i == 0, int'($signed(out_i)), 0);
        idle(1);
        check("R3", $signed(out_i) == 14'sd8191, int'($signed(out_i)), 8191);
        check("R3", out_q == 0, int'($signed(out_q)), 0);

        // R4: running oscillators with mixed words
        cur_req = "R4";
        set_osc(0, 32'h0147_AE14, 16'h0000, 15'd8000, 3'd4);
        set_osc(1, 32'h0A3D_70A4, 16'h4000, 15'd10000, 3'd4);
        idle(150);
        set_osc(2, 32'hF000_0000, 16'h1234, 15'd12000, 3'd4);
        idle(120);

        // R5: persistent clear
        cur_req = "R5";
        wr(1, 3, 32'd1);
        idle(30);
        wr(1, 3, 32'd0);
        idle(30);

        // R6: one-shot clear
        cur_req = "R6";
        wr(2, 3, 32'd2);
        idle(25);

        // R9: unused indices
        cur_req = "R9";
        for (int o = 5; o < 8; o++) set_osc(o, 32'h0100_0000, 16'h0000, 15'd32767, 3'd4);
        idle(20);
        check("R8", sat_flag == 0, int'(sat_flag), 0);

        // R7/R8: all five aligned at full scale
        cur_req = "R7";
        for (int o = 0; o < 5; o++) set_osc(o, 32'd0, 16'h0000, 15'd32767, 3'd5);
        idle(8);
        check("R7", $signed(out_i) == 14'sd8191, int'($signed(out_i)), 8191);
        check("R8", sat_flag == 1, int'(sat_flag), 1);
        for (int o = 0; o < 5; o++) set_osc(o, 32'd0, 16'h8000, 15'd32767, 3'd5);
        idle(8);
        check("R7", $signed(out_i) == -14'sd8192, int'($signed(out_i)), -8192);
        check("R7", out_q == 0, int'($signed(out_q)), 0);

        cur_req = "R8";
        for (int o = 0; o < 5; o++) set_osc(o, 32'd0, 16'h0000, 15'd6000, 3'd5);
        idle(8);
        check("R7", $signed(out_i) == 14'sd7495, int'($signed(out_i)), 7495);
        check("R8", sat_flag == 1, int'(sat_flag), 1);

        // Mixed wideband run
        cur_req = "R4";
        for (int o = 0; o < 5; o++)
            set_osc(o, $urandom, 16'($urandom), 15'($urandom), 3'd4);
        idle(300);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule